// File: doc/BRIEF.md
# Comb-Filter Tempo Estimator

This block estimates the tempo of one frequency band of an audio stream. Signed 16-bit samples arrive at the audio rate (22050 Hz nominal) with a valid strobe. The block takes the magnitude of each accepted sample and averages the magnitudes in groups of 512. This gives one envelope value per frame, at about 43 frames per second.

Every envelope value drives a bank of feedback comb filters at the same time. Each filter has its own lag in frames, and each lag matches one candidate tempo in beats per minute. A filter whose lag equals the beat period of the music reinforces itself, so its output grows larger than the output of the other filters. The block sums the squared output of each filter over an analysis window of a fixed number of frames. When a window closes, it reports the index and the BPM of the filter with the largest sum.

Band splitting, fusion across bands and any later smoothing happen outside this block. Filter gain, lags and window length are fixed at elaboration time.

Top module: `comb_tempo_estimator`

## Requirements
- R1: The magnitude of each accepted sample (two's complement, sampleValid high) is its absolute value. -32768 gives 32768.
- R2: Every 512 accepted magnitudes form one frame. The envelope value of the frame is their sum shifted right by 9 (floor). Cycles with sampleValid low change nothing.
- R3: For each envelope value x, a filter with lag L computes y = x + floor(alpha * y_L / 16). Here y_L is that filter's output from L frames earlier, and alpha is 12 by default. Delay lines start at zero.
- R4: Filter i has lag L = round(60 * 22050 / (512 * BPM_i)). The default BPM list is 60, 90, 120, 150 for indices 0 to 3, which gives lags 43, 29, 22 and 17.
- R5: Each filter's energy is the sum of y*y over a window of 64 frames. The sum saturates at 2^32-1 and restarts with the first frame of each new window.
- R6: At the end of each window, resultIdx takes the index of the largest energy. On a tie, the lower index wins. resultBpm takes that filter's BPM. Both hold their values until the next result.
- R7: resultValid is high for exactly one cycle. It rises after the third rising edge, counting the edge that accepts the last sample of the window's last frame.
- R8: After reset all outputs are zero, and no result appears until the first full window completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Strobe: sampleIn holds a new sample |
| sampleIn | input | 16 | Signed audio sample of one band |
| resultValid | output | 1 | One-cycle pulse marking a new tempo result |
| resultIdx | output | 2 | Index of the filter with the most energy |
| resultBpm | output | 9 | BPM of the selected filter |

## Verification
A result is due on the third rising edge, counting the edge that accepts the last sample of a window. That sample ends the frame, one edge later the energies update, and one edge after that the result registers. The reference model in the bench has the same three steps: a pending-envelope flag and a pending-pick flag, each applied on the next clock. The bench compares resultValid, resultIdx and resultBpm on every falling edge. A result that comes one cycle early or late is therefore caught. Three windows are checked against fixed expected picks: an impulse train at 120 BPM, a gapped impulse train at 90 BPM with junk data on invalid cycles, and a full-scale negative level that saturates every energy and so tests the tie rule.

// File: rtl/tempo_pkg.sv
package tempo_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic accEn;     // accept sample magnitude into the frame sum
    logic frameEnd;  // this accepted sample closes the frame
    logic envStb;    // envelope register holds a fresh frame value
    logic winClr;    // current envelope is the first frame of a window
    logic pickStb;   // energies are final: choose the winner
  } ctl_t;

  // Lag in frames, rounded to nearest: 60*rate/(2^frameLog2 * bpm)
  function automatic int lagFrames(input int bpm, input int rate, input int frameLog2);
    int twice;
    twice = (120 * rate) / ((1 << frameLog2) * bpm);
    return (twice + 1) / 2;
  endfunction

endpackage

// File: rtl/tempo_ctrl.sv
module tempo_ctrl #(
  parameter int FRAME_LOG2 = 9,
  parameter int WIN_FRAMES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  output tempo_pkg::ctl_t   ctl
);
  localparam int FC_W = $clog2(WIN_FRAMES + 1);

  logic [FRAME_LOG2-1:0] sampleCnt;
  logic [FC_W-1:0]       frameCnt;
  logic                  envQ, pickQ;
  logic                  frameEnd, winLast;

  assign frameEnd = sampleValid && (sampleCnt == '1);
  assign winLast  = envQ && (frameCnt == FC_W'(WIN_FRAMES - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleCnt <= '0;
      frameCnt  <= '0;
      envQ      <= 1'b0;
      pickQ     <= 1'b0;
    end else begin
      if (sampleValid) sampleCnt <= sampleCnt + 1'b1;
      envQ  <= frameEnd;
      pickQ <= winLast;
      if (envQ) frameCnt <= winLast ? '0 : frameCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.accEn    = sampleValid;
    ctl.frameEnd = frameEnd;
    ctl.envStb   = envQ;
    ctl.winClr   = (frameCnt == '0);
    ctl.pickStb  = pickQ;
  end

  // R2
  env_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.envStb |=> !ctl.envStb);

endmodule

// File: rtl/comb_resonator.sv
module comb_resonator #(
  parameter int X_W   = 16,
  parameter int Y_W   = 20,
  parameter int E_W   = 32,
  parameter int LAG   = 22,
  parameter int ALPHA = 12
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           stb,
  input  logic           clr,
  input  logic [X_W-1:0] x,
  output logic [E_W-1:0] energy
);
  localparam int P_W  = (LAG > 1) ? $clog2(LAG) : 1;
  localparam int SQ_W = 2 * Y_W;
  localparam int S_W  = Y_W + 4;

  logic [Y_W-1:0]  dly [LAG];
  logic [P_W-1:0]  ptr;
  logic [Y_W-1:0]  echo, yNow;
  logic [S_W-1:0]  scaled;
  logic [SQ_W-1:0] sq;
  logic [SQ_W:0]   sum;
  logic [E_W-1:0]  nextE;

  always_comb begin
    echo   = dly[ptr];
    scaled = S_W'(echo) * S_W'(ALPHA);
    yNow   = Y_W'(x) + Y_W'(scaled >> 4);
    sq     = SQ_W'(yNow) * SQ_W'(yNow);
    sum    = (clr ? '0 : (SQ_W + 1)'(energy)) + (SQ_W + 1)'(sq);
    nextE  = (sum > (SQ_W + 1)'({E_W{1'b1}})) ? '1 : E_W'(sum);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LAG; i++) dly[i] <= '0;
      ptr    <= '0;
      energy <= '0;
    end else if (stb) begin
      dly[ptr] <= yNow;
      ptr      <= (ptr == P_W'(LAG - 1)) ? '0 : ptr + 1'b1;
      energy   <= nextE;
    end
  end

  // R5
  energy_grow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb && !clr) |=> (energy >= $past(energy)));

  // R5
  energy_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb && !clr && energy == '1) |=> (energy == '1));

endmodule

// File: rtl/tempo_datapath.sv
module tempo_datapath #(
  parameter int SAMPLE_W    = 16,
  parameter int FRAME_LOG2  = 9,
  parameter int NUM_FILT    = 4,
  parameter int BPM_LIST [NUM_FILT] = '{60, 90, 120, 150},
  parameter int SAMPLE_RATE = 22050,
  parameter int ALPHA       = 12,
  parameter int E_W         = 32,
  parameter int BPM_W       = 9,
  parameter int IDX_W       = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  tempo_pkg::ctl_t     ctl,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic                resultValid,
  output logic [IDX_W-1:0]    resultIdx,
  output logic [BPM_W-1:0]    resultBpm
);
  localparam int ACC_W = SAMPLE_W + FRAME_LOG2;
  localparam int Y_W   = SAMPLE_W + 4;

  logic [SAMPLE_W-1:0] mag;
  logic [ACC_W-1:0]    accSum, frameTotal;
  logic [SAMPLE_W-1:0] envReg;
  logic [E_W-1:0]      energy [NUM_FILT];
  logic [E_W-1:0]      bestE;
  logic [IDX_W-1:0]    bestIdx;
  logic [BPM_W-1:0]    bestBpm;

  always_comb begin
    mag        = sampleIn[SAMPLE_W-1] ? (~sampleIn + 1'b1) : sampleIn;
    frameTotal = accSum + ACC_W'(mag);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accSum <= '0;
      envReg <= '0;
    end else if (ctl.frameEnd) begin
      envReg <= SAMPLE_W'(frameTotal >> FRAME_LOG2);
      accSum <= '0;
    end else if (ctl.accEn) begin
      accSum <= frameTotal;
    end
  end

  for (genvar g = 0; g < NUM_FILT; g++) begin : g_bank
    localparam int LAG = tempo_pkg::lagFrames(BPM_LIST[g], SAMPLE_RATE, FRAME_LOG2);
    comb_resonator #(
      .X_W(SAMPLE_W), .Y_W(Y_W), .E_W(E_W), .LAG(LAG), .ALPHA(ALPHA)
    ) u_res (
      .clk(clk), .rstN(rstN), .stb(ctl.envStb), .clr(ctl.winClr),
      .x(envReg), .energy(energy[g])
    );
  end

  always_comb begin
    bestIdx = '0;
    bestE   = energy[0];
    for (int i = 1; i < NUM_FILT; i++) begin
      if (energy[i] > bestE) begin
        bestE   = energy[i];
        bestIdx = IDX_W'(i);
      end
    end
    bestBpm = '0;
    for (int i = 0; i < NUM_FILT; i++) begin
      if (bestIdx == IDX_W'(i)) bestBpm = BPM_W'(BPM_LIST[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      resultIdx   <= '0;
      resultBpm   <= '0;
    end else begin
      resultValid <= ctl.pickStb;
      if (ctl.pickStb) begin
        resultIdx <= bestIdx;
        resultBpm <= bestBpm;
      end
    end
  end

  // R7
  pick_to_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pickStb |=> resultValid);

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R6
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.pickStb |=> ($stable(resultIdx) && $stable(resultBpm)));

endmodule

// File: rtl/comb_tempo_estimator.sv
module comb_tempo_estimator #(
  parameter int SAMPLE_W    = 16,
  parameter int FRAME_LOG2  = 9,
  parameter int WIN_FRAMES  = 64,
  parameter int NUM_FILT    = 4,
  parameter int BPM_LIST [NUM_FILT] = '{60, 90, 120, 150},
  parameter int SAMPLE_RATE = 22050,
  parameter int ALPHA       = 12,
  parameter int E_W         = 32,
  parameter int BPM_W       = 9,
  localparam int IDX_W      = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic                resultValid,
  output logic [IDX_W-1:0]    resultIdx,
  output logic [BPM_W-1:0]    resultBpm
);
  tempo_pkg::ctl_t ctl;

  tempo_ctrl #(.FRAME_LOG2(FRAME_LOG2), .WIN_FRAMES(WIN_FRAMES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .ctl(ctl)
  );

  tempo_datapath #(
    .SAMPLE_W(SAMPLE_W), .FRAME_LOG2(FRAME_LOG2), .NUM_FILT(NUM_FILT),
    .BPM_LIST(BPM_LIST), .SAMPLE_RATE(SAMPLE_RATE), .ALPHA(ALPHA),
    .E_W(E_W), .BPM_W(BPM_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sampleIn(sampleIn),
    .resultValid(resultValid), .resultIdx(resultIdx), .resultBpm(resultBpm)
  );

endmodule

// File: tb/comb_tempo_estimator_tb.sv
module comb_tempo_estimator_tb;
  localparam int NF = 4;
  localparam int FRAME = 512;
  localparam int WIN = 64;
  localparam int ALPHA = 12;
  localparam longint EMAX = 64'd4294967295;
  localparam int BPMS [NF] = '{60, 90, 120, 150};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [15:0] sampleIn = '0;
  logic        resultValid;
  logic [1:0]  resultIdx;
  logic [8:0]  resultBpm;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  comb_tempo_estimator u_dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .resultValid(resultValid), .resultIdx(resultIdx), .resultBpm(resultBpm)
  );

  // ---------------- behavioural reference ----------------
  longint dly [NF][$];
  longint mE [NF];
  longint mSum, mEnv;
  int mCnt, mFrame;
  bit envPend, pickPend, clrPend, mValid;
  int mIdx, mBpm;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int f = 0; f < NF; f++) begin
        int lag;
        lag = int'(60.0 * 22050.0 / (512.0 * real'(BPMS[f])));  // R4
        dly[f].delete();
        repeat (lag) dly[f].push_back(0);
        mE[f] = 0;
      end
      mSum = 0; mEnv = 0; mCnt = 0; mFrame = 0;
      envPend = 0; pickPend = 0; clrPend = 1; mValid = 0; mIdx = 0; mBpm = 0;
    end else begin
      mValid = 0;
      if (pickPend) begin  // R6
        int best;
        best = 0;
        for (int f = 1; f < NF; f++) if (mE[f] > mE[best]) best = f;
        mIdx = best; mBpm = BPMS[best]; mValid = 1;
      end
      pickPend = 0;
      if (envPend) begin  // R3, R5
        for (int f = 0; f < NF; f++) begin
          longint old, y, e;
          old = dly[f].pop_front();
          y = mEnv + ((ALPHA * old) >> 4);
          dly[f].push_back(y);
          e = clrPend ? 0 : mE[f];
          e = e + y * y;
          if (e > EMAX) e = EMAX;
          mE[f] = e;
        end
        clrPend = 0;
        mFrame++;
        if (mFrame == WIN) begin mFrame = 0; pickPend = 1; clrPend = 1; end
      end
      envPend = 0;
      if (sampleValid) begin  // R1, R2
        longint s;
        s = longint'($signed(sampleIn));
        mSum += (s < 0) ? -s : s;
        mCnt++;
        if (mCnt == FRAME) begin mEnv = mSum / FRAME; mSum = 0; mCnt = 0; envPend = 1; end
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  int resCount = 0;
  int expIdx [3] = '{2, 1, 0};

  always @(negedge clk) begin
    if (rstN && !done) begin
      compared++;
      if (resultValid !== mValid || resultIdx !== 2'(mIdx) || resultBpm !== 9'(mBpm)) begin
        mismatched++;
        $display("FAIL R1/R2/R3/R7 cycle compare: valid=%0b idx=%0d bpm=%0d expected valid=%0b idx=%0d bpm=%0d",
                 resultValid, resultIdx, resultBpm, mValid, mIdx, mBpm);
      end
      if (resultValid === 1'b1) begin
        if (resCount < 3) begin
          compared++;
          // R6 directed pick (window 3 is the all-saturated tie, R5)
          if (resultIdx !== 2'(expIdx[resCount]) || resultBpm !== 9'(BPMS[expIdx[resCount]])) begin
            mismatched++;
            $display("FAIL R6 window %0d pick: idx=%0d bpm=%0d expected idx=%0d bpm=%0d",
                     resCount, resultIdx, resultBpm, expIdx[resCount], BPMS[expIdx[resCount]]);
          end
        end
        resCount++;
      end
    end
  end

  task automatic sendFrame(input int amp, input bit gappy, input bit fullNeg);
    int sent = 0;
    int cyc = 0;
    while (sent < FRAME) begin
      @(negedge clk);
      cyc++;
      if (gappy && (cyc % 4 == 0)) begin
        sampleValid = 1'b0;
        sampleIn = 16'h7abc;  // junk, must be ignored (R2)
      end else begin
        sampleValid = 1'b1;
        if (fullNeg) sampleIn = 16'h8000;
        else sampleIn = (sent % 2 == 1) ? 16'(amp) : 16'(-amp);
        sent++;
      end
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compared++;
    // R8 reset state
    if (resultValid !== 1'b0 || resultIdx !== 2'd0 || resultBpm !== 9'd0) begin
      mismatched++;
      $display("FAIL R8 reset: valid=%0b idx=%0d bpm=%0d expected 0 0 0", resultValid, resultIdx, resultBpm);
    end
    for (int k = 0; k < WIN; k++) sendFrame((k % 22 == 0) ? 1000 : 0, 1'b0, 1'b0);
    for (int k = 0; k < WIN; k++) sendFrame((k % 29 == 0) ? 3000 : 0, 1'b1, 1'b0);
    for (int k = 0; k < WIN; k++) sendFrame(0, 1'b0, 1'b1);
    @(negedge clk);
    sampleValid = 1'b0;
    sampleIn = '0;
    repeat (10) @(negedge clk);
    compared++;
    // R7 one pulse per window
    if (resCount != 3) begin
      mismatched++;
      $display("FAIL R7 result count: %0d expected 3", resCount);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (160000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL R7 watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule